// File: doc/BRIEF.md
# Wired-OR Bus Collision Arbiter

This block lets one station share a single serial transmit line with several other stations. The line carries NRZ bits, and the stations' outputs are combined by a logical OR. The block runs on the bit clock, so one cycle carries one bit. While the station holds the line, the block passes the local transmit bit to the bus driver. In the same cycle it compares that bit with the bus level that comes back on the feedback input. If the local bit is 0 and the bus reads 1, another station is also transmitting. The block then withdraws at once, releases the line by driving 0, and reports a one-cycle collision.

Before a station may start, the feedback must show a run of consecutive 1 bits, read as an idle line. The run must be 8 bits long, plus one extra bit per unit of the station's priority class. Different classes therefore resolve contention in a fixed order. After a frame completes without a collision, the station lengthens its own required run by 2 bits. It keeps that penalty until it sees a 0 on the line while it is not transmitting, which marks another station's traffic. This rotating element means a busy high-priority station cannot lock out the others, so each station gains access within a bounded time. Collision detection is active from the first bit after the grant, so a clash is already caught during the opening flag. Frame formatting is left to the logic around the block.

Top module: `wob_bus_arbiter`

## Requirements
- R1: Synchronous active-low reset clears tx_grant, collision and bus_drive, sets the idle run count to zero and clears the fairness penalty.
- R2: bus_drive equals tx_bit in every cycle where tx_grant is 1, and is 0 in every cycle where tx_grant is 0.
- R3: With tx_req at 1 and bus_fb at 1, tx_grant becomes 1 at the clock edge that samples the Nth consecutive 1 on bus_fb. N = 8 + prio_class + penalty, with prio_class taken as an unsigned number.
- R4: A 0 sampled on bus_fb while the station is not transmitting restarts the count of consecutive 1s from zero.
- R5: tx_grant stays 0 while tx_req is 0, however long the line is idle. If tx_req rises after the run already exceeds N, tx_grant becomes 1 at the next edge that samples a 1.
- R6: Suppose an edge samples tx_grant=1, tx_bit=0 and bus_fb=1. After that edge, tx_grant is 0, bus_drive is 0 and collision is 1. In the following cycle collision is 0 again.
- R7: While tx_grant is 1, an edge that samples tx_bit=1, or samples bus_fb=0, raises no collision and keeps tx_grant at 1.
- R8: frame_end sampled at 1 while tx_grant is 1 (and no collision in that cycle) drops tx_grant at that edge and sets the penalty to 2 idle bits.
- R9: The penalty returns to 0 when a 0 is sampled on bus_fb while tx_grant is 0.
- R10: frame_end sampled while tx_grant is 0 has no effect and leaves the penalty unchanged.
- R11: When a collision and frame_end happen in the same cycle, the collision takes precedence and the penalty is not raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one bit per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_bit | input | 1 | Local NRZ bit to place on the line |
| tx_req | input | 1 | Station wants the line |
| bus_fb | input | 1 | Level read back from the OR-connected line |
| prio_class | input | PRIO_W (3) | Fixed priority class; adds this many idle bits to the wait |
| frame_end | input | 1 | One-cycle pulse marking a finished frame |
| bus_drive | output | 1 | Data to the line driver; 0 when released |
| tx_grant | output | 1 | Station currently holds the line |
| collision | output | 1 | One-cycle pulse after a lost bit comparison |

## Verification
A table sweeps the priority class across 0, small values and the maximum on a quiet line. It also places a single 0 early, midway and at the last bit before the threshold. Together these show that the class adds exactly one bit per unit, and that any 0 restarts the idle run instead of pausing it. Directed sequences then feed the granted station all four pairs of local bit and feedback. Only the pair with local 0 and bus 1 may withdraw the station. Further sequences count the idle bits needed after a clean frame, after a foreign 0, after a stray frame_end and after a collision that coincides with frame_end. These separate the raised penalty from the cleared one and show which event takes precedence.

// File: rtl/wob_pkg.sv
// Shared types for the wired-OR bus arbiter.
// Assumes: one state bit is enough, since the station either listens or sends.
package wob_pkg;
    typedef enum logic {
        ST_LISTEN = 1'b0,
        ST_SEND   = 1'b1
    } wob_state_e;
endpackage

// File: rtl/wob_idle_timer.sv
// Counts consecutive 1 bits seen on the bus feedback while listening.
// Assumes: one bit per clock; the count saturates at LIMIT and is cleared
// by any 0 on the line or while the station itself is sending.
module wob_idle_timer #(
    parameter int CNT_W = 5,
    parameter int LIMIT = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bus_fb,
    output logic [CNT_W-1:0] run_len
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(LIMIT);

    // Purpose: advance, hold or restart the idle run length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (clear || !bus_fb) begin
            run_len <= '0;
        end else if (run_len != SAT) begin
            run_len <= run_len + 1'b1;
        end
    end
endmodule

// File: rtl/wob_fair_credit.sv
// Holds the rotating fairness penalty in extra idle bits.
// Assumes: frame_done pulses only for a frame that ended without collision;
// foreign traffic shows up as a 0 on the line while the station listens.
module wob_fair_credit #(
    parameter int CNT_W    = 5,
    parameter int ROT_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic             listening,
    input  logic             bus_fb,
    output logic [CNT_W-1:0] penalty
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(ROT_STEP);

    // Purpose: raise the penalty after an own frame, drop it on foreign traffic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            penalty <= '0;
        end else if (frame_done) begin
            penalty <= STEP;
        end else if (listening && !bus_fb) begin
            penalty <= '0;
        end
    end
endmodule

// File: rtl/wob_collide_det.sv
// Compares the local bit with the OR-connected bus level while sending.
// Assumes: the feedback is valid in the same bit cycle as the driven bit.
module wob_collide_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sending,
    input  logic tx_bit,
    input  logic bus_fb,
    output logic hit,
    output logic collision
);
    // Purpose: flag a lost bit, where the local bit is 0 but the bus reads 1.
    always_comb begin
        hit = sending && !tx_bit && bus_fb;
    end

    // Purpose: turn a lost bit into a one-cycle collision report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            collision <= 1'b0;
        end else begin
            collision <= hit;
        end
    end
endmodule

// File: rtl/wob_access_fsm.sv
// Decides when the station takes and gives up the line.
// Assumes: the idle run, the penalty and the lost-bit flag come from sibling
// blocks; the threshold is IDLE_BITS plus the priority class plus the penalty.
module wob_access_fsm
    import wob_pkg::*;
#(
    parameter int IDLE_BITS = 8,
    parameter int PRIO_W    = 3,
    parameter int CNT_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_req,
    input  logic              bus_fb,
    input  logic [PRIO_W-1:0] prio_class,
    input  logic [CNT_W-1:0]  penalty,
    input  logic [CNT_W-1:0]  run_len,
    input  logic              hit,
    input  logic              frame_end,
    output logic              sending,
    output logic              frame_done
);
    wob_state_e       state_q;
    wob_state_e       state_d;
    logic [CNT_W:0]   needed;
    logic [CNT_W:0]   run_next;
    logic             may_start;

    // Purpose: form the idle threshold and the run length including this bit.
    always_comb begin
        needed    = (CNT_W+1)'(IDLE_BITS) + (CNT_W+1)'(prio_class) + {1'b0, penalty};
        run_next  = {1'b0, run_len} + 1'b1;
        may_start = tx_req && bus_fb && (run_next >= needed);
    end

    // Purpose: choose the next state; a lost bit outranks the end of frame.
    always_comb begin
        state_d    = state_q;
        frame_done = 1'b0;
        unique case (state_q)
            ST_LISTEN: begin
                if (may_start) state_d = ST_SEND;
            end
            ST_SEND: begin
                if (hit) begin
                    state_d = ST_LISTEN;
                end else if (frame_end) begin
                    state_d    = ST_LISTEN;
                    frame_done = 1'b1;
                end
            end
            default: state_d = ST_LISTEN;
        endcase
    end

    // Purpose: hold the state, returning to listening on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LISTEN;
        end else begin
            state_q <= state_d;
        end
    end

    assign sending = (state_q == ST_SEND);
endmodule

// File: rtl/wob_bus_arbiter.sv
// Top level of the wired-OR bus collision arbiter.
// Assumes: NRZ bits, one per clock; the line is the OR of all stations and
// reads back on bus_fb in the same cycle; idle line level is 1.
module wob_bus_arbiter #(
    parameter int IDLE_BITS = 8,
    parameter int PRIO_W    = 3,
    parameter int ROT_STEP  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_bit,
    input  logic              tx_req,
    input  logic              bus_fb,
    input  logic [PRIO_W-1:0] prio_class,
    input  logic              frame_end,
    output logic              bus_drive,
    output logic              tx_grant,
    output logic              collision
);
    localparam int MAX_WAIT = IDLE_BITS + (2**PRIO_W - 1) + ROT_STEP;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    logic             sending;
    logic             hit;
    logic             frame_done;
    logic [CNT_W-1:0] run_len;
    logic [CNT_W-1:0] penalty;

    wob_idle_timer #(
        .CNT_W (CNT_W),
        .LIMIT (MAX_WAIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (sending),
        .bus_fb  (bus_fb),
        .run_len (run_len)
    );

    wob_fair_credit #(
        .CNT_W    (CNT_W),
        .ROT_STEP (ROT_STEP)
    ) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .listening  (!sending),
        .bus_fb     (bus_fb),
        .penalty    (penalty)
    );

    wob_collide_det u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sending   (sending),
        .tx_bit    (tx_bit),
        .bus_fb    (bus_fb),
        .hit       (hit),
        .collision (collision)
    );

    wob_access_fsm #(
        .IDLE_BITS (IDLE_BITS),
        .PRIO_W    (PRIO_W),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_req     (tx_req),
        .bus_fb     (bus_fb),
        .prio_class (prio_class),
        .penalty    (penalty),
        .run_len    (run_len),
        .hit        (hit),
        .frame_end  (frame_end),
        .sending    (sending),
        .frame_done (frame_done)
    );

    // Purpose: drive the line only while holding it; otherwise release to 0.
    always_comb begin
        tx_grant  = sending;
        bus_drive = sending && tx_bit;
    end
endmodule

// File: rtl/wob_bus_arbiter_chk.sv
// Property checker for the arbiter's port behaviour, bound to the top.
// Assumes: ports are sampled on the rising bit clock.
module wob_bus_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_bit,
    input logic tx_req,
    input logic bus_fb,
    input logic frame_end,
    input logic bus_drive,
    input logic tx_grant,
    input logic collision
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!tx_grant && !collision && !bus_drive));

    a_r2_released_low: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_grant |-> !bus_drive);

    a_r3_start_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_grant) |-> $past(bus_fb && tx_req));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        collision |=> !collision);

    a_r6_withdrawn: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> !tx_grant);

    a_r6_lost_bit_cause: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> $past(tx_grant && !tx_bit && bus_fb));

    a_r7_no_false_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_grant && (tx_bit || !bus_fb)) |=> !collision);

    a_r8_frame_release: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_grant && frame_end) |=> !tx_grant);
endmodule

bind wob_bus_arbiter wob_bus_arbiter_chk u_chk (.*);

// File: tb/wob_bus_arbiter_test.sv
// Self-checking bench for the wired-OR bus arbiter.
module wob_bus_arbiter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_bit = 1'b1;
    logic       tx_req = 1'b0;
    logic       bus_fb = 1'b1;
    logic [2:0] prio_class = 3'd0;
    logic       frame_end = 1'b0;
    logic       bus_drive;
    logic       tx_grant;
    logic       collision;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [7:0] prio;
        logic [7:0] zero_at;
        logic [7:0] expect_edge;
    } vec_t;

    // prio class, edge carrying a single 0 (0 = none), edge of grant
    localparam vec_t VECS [8] = '{
        '{8'd0, 8'd0, 8'd8},
        '{8'd3, 8'd0, 8'd11},
        '{8'd7, 8'd0, 8'd15},
        '{8'd1, 8'd0, 8'd9},
        '{8'd2, 8'd5, 8'd15},
        '{8'd0, 8'd3, 8'd11},
        '{8'd1, 8'd9, 8'd18},
        '{8'd5, 8'd1, 8'd14}
    };

    wob_bus_arbiter uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_bit     (tx_bit),
        .tx_req     (tx_req),
        .bus_fb     (bus_fb),
        .prio_class (prio_class),
        .frame_end  (frame_end),
        .bus_drive  (bus_drive),
        .tx_grant   (tx_grant),
        .collision  (collision)
    );

    always #2 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    // Drives 1s (with one 0 at edge zero_at) until grant; returns the edge number.
    task automatic run_to_grant(input int zero_at, output int edge_no);
        edge_no = -1;
        for (int e = 1; e <= 60; e++) begin
            bus_fb = (e == zero_at) ? 1'b0 : 1'b1;
            tick();
            if (tx_grant) begin
                edge_no = e;
                break;
            end
        end
    endtask

    initial begin
        int k;
        do_reset();
        // R1: quiet outputs after reset
        chk("R1 grant after reset", int'(tx_grant), 0);
        chk("R1 collision after reset", int'(collision), 0);
        chk("R1 drive after reset", int'(bus_drive), 0);

        // R3 R4 R12-like sweep: threshold vectors
        foreach (VECS[i]) begin
            do_reset();
            prio_class = VECS[i].prio[2:0];
            tx_req = 1'b1;
            tx_bit = 1'b1;
            run_to_grant(int'(VECS[i].zero_at), k);
            chk((VECS[i].zero_at == 0) ? "R3 grant edge" : "R4 restart grant edge",
                k, int'(VECS[i].expect_edge));
        end

        // R1: reset while sending releases the line
        chk("R2 drive while granted", int'(bus_drive), 1);
        rst_n = 1'b0;
        tick();
        chk("R1 grant after mid reset", int'(tx_grant), 0);
        chk("R1 drive after mid reset", int'(bus_drive), 0);
        rst_n = 1'b1;

        // R7 and R6: bit comparison outcomes
        do_reset();
        prio_class = 3'd0;
        tx_req = 1'b1;
        tx_bit = 1'b1;
        run_to_grant(0, k);
        chk("R3 grant edge prio 0", k, 8);
        tx_bit = 1'b0;
        bus_fb = 1'b0;
        #1;
        chk("R2 drive follows 0", int'(bus_drive), 0);
        tick();
        chk("R7 no collision on 0/0", int'(collision), 0);
        chk("R7 grant kept on 0/0", int'(tx_grant), 1);
        tx_bit = 1'b1;
        bus_fb = 1'b1;
        #1;
        chk("R2 drive follows 1", int'(bus_drive), 1);
        tick();
        chk("R7 no collision on 1/1", int'(collision), 0);
        chk("R7 grant kept on 1/1", int'(tx_grant), 1);
        tx_bit = 1'b0;
        bus_fb = 1'b1;
        tick();
        chk("R6 collision raised", int'(collision), 1);
        chk("R6 grant withdrawn", int'(tx_grant), 0);
        tx_bit = 1'b1;
        #1;
        chk("R6 line released", int'(bus_drive), 0);
        tick();
        chk("R6 collision one cycle", int'(collision), 0);

        // R5: no grant without request, then immediate start
        do_reset();
        tx_req = 1'b0;
        bus_fb = 1'b1;
        repeat (20) tick();
        chk("R5 no grant without request", int'(tx_grant), 0);
        tx_req = 1'b1;
        tick();
        chk("R5 grant on next idle bit", int'(tx_grant), 1);

        // R8 and R9: penalty after a clean frame, cleared by foreign traffic
        do_reset();
        tx_req = 1'b1;
        tx_bit = 1'b1;
        run_to_grant(0, k);
        frame_end = 1'b1;
        tick();
        frame_end = 1'b0;
        chk("R8 grant dropped at frame end", int'(tx_grant), 0);
        chk("R8 no collision at frame end", int'(collision), 0);
        run_to_grant(0, k);
        chk("R8 penalty adds two idle bits", k, 10);
        frame_end = 1'b1;
        tick();
        frame_end = 1'b0;
        run_to_grant(1, k);
        chk("R9 penalty cleared by foreign 0", k, 9);

        // R10: frame end while listening changes nothing
        do_reset();
        tx_req = 1'b0;
        bus_fb = 1'b0;
        frame_end = 1'b1;
        tick();
        frame_end = 1'b0;
        tx_req = 1'b1;
        run_to_grant(0, k);
        chk("R10 stray frame end ignored", k, 8);

        // R11: collision outranks a coinciding frame end
        do_reset();
        tx_req = 1'b1;
        tx_bit = 1'b1;
        run_to_grant(0, k);
        tx_bit = 1'b0;
        bus_fb = 1'b1;
        frame_end = 1'b1;
        tick();
        frame_end = 1'b0;
        tx_bit = 1'b1;
        chk("R11 collision wins", int'(collision), 1);
        run_to_grant(0, k);
        chk("R11 no penalty after collision", k, 8);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule